// File: doc/BRIEF.md
# Banked Private Interrupt State Bank

This block keeps the per-interrupt state of the 32 interrupts private to one processing element: 16 software-generated interrupts (IDs 0 to 15) and 16 peripheral interrupts (IDs 16 to 31). For each interrupt it stores a group bit, a group-modifier bit, enable, pending and active flags, an 8-bit priority, and a trigger type. Each software-generated interrupt also has a 2-bit level that says how far the non-secure side may raise it. Software reaches this state through a word-wide register port. Each access on that port carries a secure flag. A global security-disable input selects how the group and modifier bits are read.

The block works out a security group for every interrupt. On a non-secure access with security enabled, it hides the bits of interrupts that are not non-secure group 1. On those accesses, priorities are read and written in a compressed non-secure view. The block also filters requests for software-generated interrupts against their group and access level. It accepts peripheral request pulses, and it takes activate and deactivate strobes from the interrupt acknowledge path. The enable, pending, active and resolved-group vectors are driven out for a downstream priority arbiter. A one-cycle pulse tells that arbiter when new pending state has appeared.

Top module: `prv_irq_bank`

## Requirements
- R1: After synchronous reset, the enable, pending, active, group, modifier, access-level and priority state is zero, every peripheral interrupt is level-sensitive, `upd_pulse` is 0 and `rd_valid` is 0.
- R2: `out_grp[2n+1:2n]` gives the resolved group of interrupt n, coded as 0 for group 0, 1 for secure group 1 and 2 for non-secure group 1. With `sec_dis` high, group bit 0 resolves to 0 and group bit 1 resolves to 2. With `sec_dis` low, the pair {modifier, group} resolves as follows: 00 gives 0, 01 gives 2, 10 gives 1, 11 gives 2.
- R3: When `sec_dis` is low and the access is non-secure, the enable, pending, active, priority and trigger registers read 0 and ignore writes for every interrupt whose resolved group is not 2.
- R4: A non-secure priority read returns the stored byte shifted left by one and cut to 8 bits. A non-secure priority write stores 0x80 OR the written byte shifted right by one. Secure accesses, and any access while `sec_dis` is high, store and return the byte unchanged. Priority word k holds interrupt 4k+i in byte lane i.
- R5: A 1 written to a set register sets the matching bit and a 1 written to a clear register clears it. A 0 leaves the bit unchanged. A read of either register of a pair returns the current state of that pair.
- R6: Interrupt n of a class is described by bit 2n+1 of that class's trigger word, where 1 means edge-triggered. The software-generated word always reads as edge and ignores writes. The peripheral word is writable.
- R7: The group register ignores writes and reads 0 on non-secure accesses while `sec_dis` is low. The modifier and access-level registers do the same, and they also read 0 and ignore all writes while `sec_dis` is high.
- R8: A software-generated request for secure group 1 is treated as a group-0 request when the target resolves to group 0. A group-0 request whose target does not resolve to group 0 is dropped. Request groups use the R2 code.
- R9: With `sec_dis` low, a request with `sgi_ns` high is dropped if its target resolves to group 0 and has access level 0, or resolves to secure group 1 and has access level below 2. The access level of interrupt n is bits [2n+1:2n] of the access-level register.
- R10: Each bit j of `ppi_set` that is high sets the pending bit of interrupt 16+j on that clock edge. Peripheral and accepted software-generated requests win over a same-cycle pending clear.
- R11: An activate strobe clears the pending bit of its interrupt and sets its active bit. A deactivate strobe clears the active bit. When both strobes name the same interrupt, it ends up active.
- R12: `upd_pulse` is high for exactly the cycle after a clock edge on which at least one pending bit went from 0 to 1.
- R13: A read returns its data on `rd_data` with `rd_valid` high one cycle after the request. Unlisted word indices read 0. The word indices are: 0 group, 1 modifier, 2/3 enable set/clear, 4/5 pending set/clear, 6/7 active set/clear, 8 software trigger, 9 peripheral trigger, 10 access level, 16 to 23 priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_dis | input | 1 | Global security disable |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Access is from the secure side |
| req_addr | input | ADDR_W | Register word index |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid |
| sgi_valid | input | 1 | Software-generated interrupt request |
| sgi_id | input | SGI_ID_W | Target software interrupt |
| sgi_grp | input | 2 | Requested group (R2 code) |
| sgi_ns | input | 1 | Request comes from the non-secure side |
| ppi_set | input | NUM_LOCAL | Peripheral request pulses |
| act_valid | input | 1 | Activate strobe |
| act_id | input | ID_W | Interrupt to activate |
| deact_valid | input | 1 | Deactivate strobe |
| deact_id | input | ID_W | Interrupt to deactivate |
| out_en | output | NUM_IRQ | Enable flags |
| out_pend | output | NUM_IRQ | Pending flags |
| out_act | output | NUM_IRQ | Active flags |
| out_grp | output | 2*NUM_IRQ | Resolved group per interrupt |
| upd_pulse | output | 1 | New-pending notification |

## Verification
The embedded assertions check several rules on every cycle. They cover the cleared state after reset, that non-secure enable writes leave hidden interrupts untouched, and that the whole-register group and modifier protections hold. They also cover that peripheral pulses always reach the pending flags and that activation moves pending to active. Finally, they check the timing of the update pulse and of read data, and that group-0 requests aimed at other groups are dropped. Only the directed scenarios can show the data-dependent results: the translated priority bytes in both directions, the resolved group under each setting of `sec_dis`, the trigger words, and the software-interrupt downgrade and access-level filter, which are checked for accepted and rejected cases at the pending flags.

// File: rtl/prv_irq_pkg.sv
package prv_irq_pkg;
  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2
  } irq_grp_e;

  localparam int A_GRP       = 0;
  localparam int A_GMOD      = 1;
  localparam int A_EN_SET    = 2;
  localparam int A_EN_CLR    = 3;
  localparam int A_PD_SET    = 4;
  localparam int A_PD_CLR    = 5;
  localparam int A_AC_SET    = 6;
  localparam int A_AC_CLR    = 7;
  localparam int A_CFG_SGI   = 8;
  localparam int A_CFG_PPI   = 9;
  localparam int A_NSAC      = 10;
  localparam int A_PRIO_BASE = 16;
endpackage

// File: rtl/prv_grp_resolve.sv
module prv_grp_resolve
  import prv_irq_pkg::*;
(
  input  logic     sec_dis,
  input  logic     mod_b,
  input  logic     grp_b,
  output irq_grp_e grp_o
);
  always_comb begin
    if (sec_dis) begin
      grp_o = grp_b ? GRP_G1NS : GRP_G0;
    end else begin
      unique case ({mod_b, grp_b})
        2'b00:   grp_o = GRP_G0;
        2'b10:   grp_o = GRP_G1S;
        default: grp_o = GRP_G1NS;
      endcase
    end
  end
endmodule

// File: rtl/prv_prio_lane.sv
module prv_prio_lane #(
  parameter int PRIO_W = 8
) (
  input  logic              ns_view,
  input  logic              lane_ok,
  input  logic [PRIO_W-1:0] stored,
  input  logic [PRIO_W-1:0] wr_byte,
  output logic [PRIO_W-1:0] wr_val,
  output logic [PRIO_W-1:0] rd_val
);
  always_comb begin
    wr_val = ns_view ? {1'b1, wr_byte[PRIO_W-1:1]} : wr_byte;
    if (!lane_ok)     rd_val = '0;
    else if (ns_view) rd_val = {stored[PRIO_W-2:0], 1'b0};
    else              rd_val = stored;
  end
endmodule

// File: rtl/prv_sgi_filter.sv
module prv_sgi_filter
  import prv_irq_pkg::*;
(
  input  logic     valid,
  input  logic     sec_dis,
  input  logic     req_ns,
  input  irq_grp_e req_grp,
  input  irq_grp_e tgt_grp,
  input  logic [1:0] tgt_nsac,
  output logic     accept
);
  irq_grp_e eff_grp;
  logic     grp_drop, lvl_drop;

  always_comb begin
    eff_grp  = (tgt_grp == GRP_G0 && req_grp == GRP_G1S) ? GRP_G0 : req_grp;
    grp_drop = (eff_grp == GRP_G0) && (tgt_grp != GRP_G0);
    lvl_drop = req_ns && !sec_dis &&
               (((tgt_grp == GRP_G0)  && (tgt_nsac < 2'd1)) ||
                ((tgt_grp == GRP_G1S) && (tgt_nsac < 2'd2)));
    accept   = valid && !grp_drop && !lvl_drop;
  end

  // R8: a plain group-0 request never lands on a non-group-0 target
  always_comb begin
    if (valid && req_grp == GRP_G0 && tgt_grp != GRP_G0)
      assert_g0_drop_R8: assert (!accept);
  end
endmodule

// File: rtl/prv_irq_bank.sv
module prv_irq_bank
  import prv_irq_pkg::*;
#(
  parameter int NUM_LOCAL = 16,
  parameter int PRIO_W    = 8,
  parameter int ADDR_W    = 6,
  localparam int NUM_IRQ  = 2 * NUM_LOCAL,
  localparam int DATA_W   = NUM_IRQ,
  localparam int ID_W     = $clog2(NUM_IRQ),
  localparam int SGI_ID_W = $clog2(NUM_LOCAL)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sec_dis,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_secure,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  input  logic                 sgi_valid,
  input  logic [SGI_ID_W-1:0]  sgi_id,
  input  logic [1:0]           sgi_grp,
  input  logic                 sgi_ns,
  input  logic [NUM_LOCAL-1:0] ppi_set,
  input  logic                 act_valid,
  input  logic [ID_W-1:0]      act_id,
  input  logic                 deact_valid,
  input  logic [ID_W-1:0]      deact_id,
  output logic [NUM_IRQ-1:0]   out_en,
  output logic [NUM_IRQ-1:0]   out_pend,
  output logic [NUM_IRQ-1:0]   out_act,
  output logic [2*NUM_IRQ-1:0] out_grp,
  output logic                 upd_pulse
);
  localparam int PPW        = DATA_W / PRIO_W;
  localparam int PRIO_WORDS = NUM_IRQ / PPW;

  logic [NUM_IRQ-1:0]   en_q, pend_q, act_q, grp_q, gmod_q;
  logic [NUM_IRQ-1:0]   en_d, pend_d, act_d, grp_d, gmod_d;
  logic [NUM_LOCAL-1:0] cfg_q, cfg_d;
  logic [2*NUM_LOCAL-1:0] nsac_q, nsac_d;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q, prio_wv, prio_rv;
  logic [DATA_W-1:0]    rd_d;
  logic [NUM_IRQ-1:0]   vis;
  irq_grp_e             grp_res [NUM_IRQ];
  logic ns_blk, sec_full, wr, rd, sgi_ok;

  assign ns_blk   = !sec_dis && !req_secure;
  assign sec_full = !sec_dis && req_secure;
  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;

  // per-interrupt group resolution and priority lanes
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq
    prv_grp_resolve u_grp (
      .sec_dis(sec_dis), .mod_b(gmod_q[n]), .grp_b(grp_q[n]), .grp_o(grp_res[n])
    );
    assign vis[n] = !ns_blk || (grp_res[n] == GRP_G1NS);
    assign out_grp[2*n +: 2] = grp_res[n];
    prv_prio_lane #(.PRIO_W(PRIO_W)) u_lane (
      .ns_view(ns_blk), .lane_ok(vis[n]), .stored(prio_q[n]),
      .wr_byte(req_wdata[(n % PPW)*PRIO_W +: PRIO_W]),
      .wr_val(prio_wv[n]), .rd_val(prio_rv[n])
    );
  end

  prv_sgi_filter u_sgi (
    .valid(sgi_valid), .sec_dis(sec_dis), .req_ns(sgi_ns),
    .req_grp(irq_grp_e'(sgi_grp)), .tgt_grp(grp_res[sgi_id]),
    .tgt_nsac(nsac_q[2*sgi_id +: 2]), .accept(sgi_ok)
  );

  // next-state: register writes, then activation strobes, then request sets
  always_comb begin
    en_d = en_q; pend_d = pend_q; act_d = act_q;
    grp_d = grp_q; gmod_d = gmod_q; cfg_d = cfg_q; nsac_d = nsac_q;
    if (wr) begin
      case (req_addr)
        ADDR_W'(A_GRP):    if (!ns_blk) grp_d = req_wdata;
        ADDR_W'(A_GMOD):   if (sec_full) gmod_d = req_wdata;
        ADDR_W'(A_EN_SET): en_d   = en_q   |  (req_wdata & vis);
        ADDR_W'(A_EN_CLR): en_d   = en_q   & ~(req_wdata & vis);
        ADDR_W'(A_PD_SET): pend_d = pend_q |  (req_wdata & vis);
        ADDR_W'(A_PD_CLR): pend_d = pend_q & ~(req_wdata & vis);
        ADDR_W'(A_AC_SET): act_d  = act_q  |  (req_wdata & vis);
        ADDR_W'(A_AC_CLR): act_d  = act_q  & ~(req_wdata & vis);
        ADDR_W'(A_CFG_PPI):
          for (int j = 0; j < NUM_LOCAL; j++)
            if (vis[NUM_LOCAL+j]) cfg_d[j] = req_wdata[2*j+1];
        ADDR_W'(A_NSAC):   if (sec_full) nsac_d = req_wdata;
        default: ;
      endcase
    end
    if (deact_valid) act_d[deact_id] = 1'b0;
    if (act_valid) begin
      pend_d[act_id] = 1'b0;
      act_d[act_id]  = 1'b1;
    end
    pend_d[NUM_IRQ-1:NUM_LOCAL] = pend_d[NUM_IRQ-1:NUM_LOCAL] | ppi_set;
    if (sgi_ok) pend_d[sgi_id] = 1'b1;
  end

  // read mux
  always_comb begin
    rd_d = '0;
    case (req_addr)
      ADDR_W'(A_GRP):  if (!ns_blk) rd_d = grp_q;
      ADDR_W'(A_GMOD): if (sec_full) rd_d = gmod_q;
      ADDR_W'(A_EN_SET), ADDR_W'(A_EN_CLR): rd_d = en_q & vis;
      ADDR_W'(A_PD_SET), ADDR_W'(A_PD_CLR): rd_d = pend_q & vis;
      ADDR_W'(A_AC_SET), ADDR_W'(A_AC_CLR): rd_d = act_q & vis;
      ADDR_W'(A_CFG_SGI):
        for (int j = 0; j < NUM_LOCAL; j++) rd_d[2*j+1] = vis[j];
      ADDR_W'(A_CFG_PPI):
        for (int j = 0; j < NUM_LOCAL; j++) rd_d[2*j+1] = cfg_q[j] & vis[NUM_LOCAL+j];
      ADDR_W'(A_NSAC): if (sec_full) rd_d = nsac_q;
      default: begin
        for (int k = 0; k < PRIO_WORDS; k++)
          if (req_addr == ADDR_W'(A_PRIO_BASE + k))
            for (int i = 0; i < PPW; i++)
              rd_d[i*PRIO_W +: PRIO_W] = prio_rv[k*PPW+i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0; pend_q <= '0; act_q <= '0; grp_q <= '0; gmod_q <= '0;
      cfg_q <= '0; nsac_q <= '0; prio_q <= '0;
      rd_data <= '0; rd_valid <= 1'b0; upd_pulse <= 1'b0;
    end else begin
      en_q <= en_d; pend_q <= pend_d; act_q <= act_d; grp_q <= grp_d;
      gmod_q <= gmod_d; cfg_q <= cfg_d; nsac_q <= nsac_d;
      for (int n = 0; n < NUM_IRQ; n++)
        if (wr && vis[n] && req_addr == ADDR_W'(A_PRIO_BASE + n / PPW))
          prio_q[n] <= prio_wv[n];
      rd_valid  <= rd;
      if (rd) rd_data <= rd_d;
      upd_pulse <= |(pend_d & ~pend_q);
    end
  end

  assign out_en   = en_q;
  assign out_pend = pend_q;
  assign out_act  = act_q;

  // ---------------- assertions ----------------
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_en == '0 && out_pend == '0 && out_act == '0 && !upd_pulse));

  assert_ns_en_hidden_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && ns_blk && req_addr == ADDR_W'(A_EN_SET)) |=>
      ((out_en & ~$past(vis)) == ($past(out_en) & ~$past(vis))));

  assert_grp_ns_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && ns_blk && req_addr == ADDR_W'(A_GRP)) |=> $stable(grp_q));

  assert_gmod_secdis_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && sec_dis && req_addr == ADDR_W'(A_GMOD)) |=> $stable(gmod_q));

  assert_ppi_lands_R10: assert property (@(posedge clk) disable iff (rst)
    (|ppi_set) |=> ((out_pend[NUM_IRQ-1:NUM_LOCAL] & $past(ppi_set)) == $past(ppi_set)));

  assert_activate_R11: assert property (@(posedge clk) disable iff (rst)
    act_valid |=> out_act[$past(act_id)]);

  assert_upd_R12: assert property (@(posedge clk) disable iff (rst)
    upd_pulse == (|(out_pend & ~$past(out_pend))));

  assert_rd_valid_R13: assert property (@(posedge clk) disable iff (rst)
    rd |=> rd_valid);
endmodule

// File: tb/prv_irq_bank_tb.sv
module prv_irq_bank_tb_top;
  logic clk = 1'b0;
  logic rst, sec_dis, req_valid, req_write, req_secure;
  logic [5:0] req_addr;
  logic [31:0] req_wdata, rd_data;
  logic rd_valid;
  logic sgi_valid, sgi_ns;
  logic [3:0] sgi_id;
  logic [1:0] sgi_grp;
  logic [15:0] ppi_set;
  logic act_valid, deact_valid;
  logic [4:0] act_id, deact_id;
  logic [31:0] out_en, out_pend, out_act;
  logic [63:0] out_grp;
  logic upd_pulse;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  prv_irq_bank dut_i (
    .clk(clk), .rst(rst), .sec_dis(sec_dis), .req_valid(req_valid),
    .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .sgi_valid(sgi_valid), .sgi_id(sgi_id), .sgi_grp(sgi_grp), .sgi_ns(sgi_ns),
    .ppi_set(ppi_set), .act_valid(act_valid), .act_id(act_id),
    .deact_valid(deact_valid), .deact_id(deact_id), .out_en(out_en),
    .out_pend(out_pend), .out_act(out_act), .out_grp(out_grp), .upd_pulse(upd_pulse)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_secure = sec; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rdreg(input logic [5:0] a, input logic sec, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_secure = sec; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rd_data;
  endtask

  task automatic sgi(input logic [3:0] id, input logic [1:0] g, input logic ns);
    @(negedge clk);
    sgi_valid = 1; sgi_id = id; sgi_grp = g; sgi_ns = ns;
    @(negedge clk);
    sgi_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 en", out_en, 0); chk("R1 pend", out_pend, 0); chk("R1 act", out_act, 0);
    chk("R1 upd", upd_pulse, 0); chk("R1 rd_valid", rd_valid, 0);
    rdreg(0, 1, rv);  chk("R1 group", rv, 0);
    rdreg(16, 1, rv); chk("R1 prio", rv, 0);
    rdreg(9, 1, rv);  chk("R1 ppi cfg", rv, 0);
    rdreg(10, 1, rv); chk("R1 nsac", rv, 0);
    rdreg(30, 1, rv); chk("R13 unmapped", rv, 0); chk("R13 rd_valid", rd_valid, 1);
  endtask

  task automatic t_groups;
    wr(0, 32'h0001_000A, 1); wr(1, 32'h0000_000C, 1);
    chk("R2 grp 0..3", out_grp[7:0], 8'h98); chk("R2 grp 16,17", out_grp[35:32], 4'h2);
    rdreg(0, 1, rv); chk("R7 group secure read", rv, 32'h0001_000A);
    rdreg(0, 0, rv); chk("R7 group ns read", rv, 0);
    wr(0, 0, 0); rdreg(0, 1, rv); chk("R7 group ns write ignored", rv, 32'h0001_000A);
    rdreg(1, 1, rv); chk("R7 gmod secure read", rv, 32'hC);
    sec_dis = 1;
    @(negedge clk); chk("R2 sec_dis groups", out_grp[7:0], 8'h88);
    rdreg(0, 0, rv); chk("R7 group ns read with sec_dis", rv, 32'h0001_000A);
    wr(1, 32'hFFFF, 1); rdreg(1, 1, rv); chk("R7 gmod zero with sec_dis", rv, 0);
    sec_dis = 0;
    rdreg(1, 1, rv); chk("R7 gmod write ignored with sec_dis", rv, 32'hC);
  endtask

  task automatic t_enable;
    wr(2, 32'hFFFF_FFFF, 0); chk("R3 ns enable set", out_en, 32'h0001_000A);
    wr(2, 32'h1, 1); chk("R5 secure enable set", out_en, 32'h0001_000B);
    rdreg(3, 0, rv); chk("R3 ns enable read", rv, 32'h0001_000A);
    rdreg(3, 1, rv); chk("R5 clear-reg read", rv, 32'h0001_000B);
    wr(3, 32'hFFFF_FFFF, 0); chk("R3 ns enable clear", out_en, 32'h1);
    wr(2, 32'h0, 1); chk("R5 zero write no effect", out_en, 32'h1);
  endtask

  task automatic t_prio;
    wr(16, 32'h4030_2010, 1);
    wr(16, 32'h4433_2211, 0);
    rdreg(16, 1, rv); chk("R4 secure view", rv, 32'hA230_9110);
    rdreg(16, 0, rv); chk("R4 ns view", rv, 32'h4400_2200);
    sec_dis = 1;
    wr(17, 32'h0102_0304, 0); rdreg(17, 0, rv); chk("R4 sec_dis raw", rv, 32'h0102_0304);
    sec_dis = 0;
  endtask

  task automatic t_pending;
    wr(4, 32'h5, 1); chk("R5 pend set", out_pend, 32'h5); chk("R12 upd pulse", upd_pulse, 1);
    @(negedge clk); chk("R12 upd one cycle", upd_pulse, 0);
    wr(5, 32'h1, 1); chk("R5 pend clear", out_pend, 32'h4); chk("R12 no pulse on clear", upd_pulse, 0);
    wr(4, 32'h4, 1); chk("R12 no pulse when already set", upd_pulse, 0);
    rdreg(5, 1, rv); chk("R5 pend read via clear reg", rv, 32'h4);
  endtask

  task automatic t_active;
    @(negedge clk); act_valid = 1; act_id = 2;
    @(negedge clk); act_valid = 0;
    chk("R11 activate pend", out_pend, 0); chk("R11 activate act", out_act, 32'h4);
    @(negedge clk); deact_valid = 1; deact_id = 2;
    @(negedge clk); deact_valid = 0;
    chk("R11 deactivate", out_act, 0);
    wr(6, 32'h100, 1); chk("R5 act set", out_act, 32'h100);
    wr(7, 32'h100, 1); chk("R5 act clear", out_act, 0);
  endtask

  task automatic t_cfg;
    wr(8, 0, 1); rdreg(8, 1, rv); chk("R6 sgi cfg fixed", rv, 32'hAAAA_AAAA);
    wr(9, 32'hA, 1); rdreg(9, 1, rv); chk("R6 ppi cfg write", rv, 32'hA);
    wr(9, 0, 0); rdreg(9, 1, rv); chk("R3 ppi cfg ns write masked", rv, 32'h8);
    rdreg(9, 0, rv); chk("R3 ppi cfg ns read", rv, 0);
    rdreg(8, 0, rv); chk("R3 sgi cfg ns read", rv, 32'h88);
  endtask

  task automatic t_sgi;
    sgi(0, 2'd1, 0); chk("R8 g1s downgraded to g0", out_pend, 32'h1);
    wr(5, 32'hFFFF_FFFF, 1);
    sgi(1, 2'd0, 0); chk("R8 g0 req to g1ns dropped", out_pend, 0);
    sgi(0, 2'd2, 1); chk("R9 ns to g0 level0 dropped", out_pend, 0);
    sgi(2, 2'd1, 1); chk("R9 ns to g1s level0 dropped", out_pend, 0);
    wr(10, 32'h11, 0); rdreg(10, 1, rv); chk("R7 nsac ns write ignored", rv, 0);
    wr(10, 32'h11, 1); rdreg(10, 0, rv); chk("R7 nsac ns read", rv, 0);
    sgi(0, 2'd2, 1); chk("R9 ns to g0 level1 ok", out_pend, 32'h1);
    sgi(2, 2'd1, 1); chk("R9 ns to g1s level1 dropped", out_pend, 32'h1);
    wr(10, 32'h21, 1);
    sgi(2, 2'd1, 1); chk("R9 ns to g1s level2 ok", out_pend, 32'h5);
    wr(5, 32'hFFFF_FFFF, 1);
  endtask

  task automatic t_ppi;
    @(negedge clk); ppi_set = 16'h0020;
    @(negedge clk); ppi_set = 0;
    chk("R10 ppi pend", out_pend, 32'h0020_0000); chk("R12 ppi pulse", upd_pulse, 1);
    @(negedge clk); req_valid = 1; req_write = 1; req_secure = 1; req_addr = 5;
    req_wdata = 32'h0040_0000; ppi_set = 16'h0040;
    @(negedge clk); req_valid = 0; req_write = 0; ppi_set = 0;
    chk("R10 request beats clear", out_pend, 32'h0060_0000);
  endtask

  task automatic t_midreset;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 pend after reset", out_pend, 0); chk("R1 en after reset", out_en, 0);
    chk("R1 grp after reset", out_grp, 0);
    rdreg(9, 1, rv); chk("R1 ppi cfg after reset", rv, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; sec_dis = 0; req_valid = 0; req_write = 0; req_secure = 0;
    req_addr = 0; req_wdata = 0; sgi_valid = 0; sgi_id = 0; sgi_grp = 0; sgi_ns = 0;
    ppi_set = 0; act_valid = 0; act_id = 0; deact_valid = 0; deact_id = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset; t_groups; t_enable; t_prio; t_pending; t_active;
    t_cfg; t_sgi; t_ppi; t_midreset;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule